// File: doc/BRIEF.md
# Serial Configuration Loader with Holding Latch

This block is the three-wire programming port of a multi-output clock generator. A 160-bit configuration word arrives one bit per rising edge of a slow shift clock, with the most significant bit sent first. A strobe input copies the shifted word into a holding register. The holding register drives the live configuration, and it follows the shift register for as long as the strobe stays high. All port inputs are sampled on a fast system clock.

After reset the outputs select the buffered reference clock. A sticky flag switches the outputs to their synthesized sources at the first strobe. An active-low power-down input forces every output enable off, and it also holds a settle timer that keeps the lock indication low. The same timer clears the lock indication on every latch update and sets it again once a parameterised number of system clocks has passed.

Top module: `cfgLoader`

## Requirements
- R1: Each rising edge of `shiftClk`, as seen at a system clock edge, shifts `serData` into bit 0 of the shift register and moves earlier bits toward bit 159. After 160 shifts the first bit sent therefore sits at bit 159.
- R2: A strobe pulse copies the complete shift register into `activeCfg`.
- R3: Shifting while `strobe` is low leaves `activeCfg` unchanged.
- R4: While `strobe` is high, `activeCfg` follows the shift register and updates after every shifted bit.
- R5: `programmed` is 0 after reset, sets on the first clock with `strobe` high and stays set until reset. `outSrcSynth` is all zeros (reference source) while `programmed` is 0 and all ones once it is set.
- R6: `outEnable` is all zeros while `pwrDownN` is low and all ones while it is high.
- R7: `locked` is low on the clock after any clock with `strobe` high. It rises exactly LOCK_CYCLES system clocks after the last clock with `strobe` high.
- R8: While `pwrDownN` is low, `locked` is low and the settle timer is held. After `pwrDownN` returns high, `locked` rises LOCK_CYCLES clocks later.
- R9: After reset, `activeCfg` is zero, `programmed` is 0 and `locked` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftClk | input | 1 | Serial shift clock, sampled on clk |
| serData | input | 1 | Serial data, MSB first |
| strobe | input | 1 | Latch enable; the holding register is transparent while high |
| pwrDownN | input | 1 | Active-low power-down |
| activeCfg | output | CFG_W | Live configuration word |
| programmed | output | 1 | Sticky flag: a strobe has occurred since reset |
| outSrcSynth | output | NUM_OUT | Per-output source: 1 = synthesized, 0 = reference |
| outEnable | output | NUM_OUT | Per-output drive enable; 0 = high impedance |
| locked | output | 1 | Settle time has expired |

## Verification
The bench shifts a full word with the strobe low and checks that the live configuration does not move. A latch that is wrongly transparent would leak partial words at this point. It then shifts a second word with the strobe held high and compares the live word after every one of the 160 bits. This catches a shift in the wrong direction, a dropped bit, or a latch that only loads on the strobe edge. The settle window is probed a few clocks before and after its expected end, both after a strobe and after a power-down release, to catch off-by-window counters and a timer that ignores power-down. The reference-source default is checked before the first strobe, and again after a second reset, to catch a flag that is not sticky or does not clear.

// File: rtl/cfgLoaderPkg.sv
package cfgLoaderPkg;
  typedef struct packed {
    logic shiftEn;  // shift one bit into the shift register
    logic latchEn;  // holding register follows the shift register
  } ctrlStrobes_t;
endpackage

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgLoaderPkg::*;
#(
  parameter int CFG_W = 160
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctl,
  input  logic             serData,
  output logic [CFG_W-1:0] holdReg
);
  logic [CFG_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.shiftEn) begin
      shiftReg <= {shiftReg[CFG_W-2:0], serData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (ctl.latchEn) begin
      holdReg <= shiftReg;
    end
  end

  // R1: new bit enters at bit 0
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> shiftReg == {$past(shiftReg[CFG_W-2:0]), $past(serData)});

  // R3: latch holds while strobe low
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchEn |=> $stable(holdReg));

  // R4: transparent while strobe high
  assert_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchEn |=> holdReg == $past(shiftReg));
endmodule

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgLoaderPkg::*;
#(
  parameter int NUM_OUT     = 9,
  parameter int LOCK_CYCLES = 1000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shiftClk,
  input  logic               strobe,
  input  logic               pwrDownN,
  output ctrlStrobes_t       ctl,
  output logic               programmed,
  output logic [NUM_OUT-1:0] outSrcSynth,
  output logic [NUM_OUT-1:0] outEnable,
  output logic               locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);

  logic             shClkQ;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shClkQ <= 1'b0;
    else       shClkQ <= shiftClk;
  end

  always_comb begin
    ctl.shiftEn = shiftClk & ~shClkQ;
    ctl.latchEn = strobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       programmed <= 1'b0;
    else if (strobe) programmed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe || !pwrDownN) begin
      settleCnt <= CNT_LOAD;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign locked      = (settleCnt == '0) && pwrDownN;
  assign outSrcSynth = {NUM_OUT{programmed}};
  assign outEnable   = {NUM_OUT{pwrDownN}};

  // R5: programmed is sticky
  assert_prog_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    programmed |=> programmed);

  // R5: first strobe sets the flag
  assert_prog_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> programmed);

  // R7: latch update drops lock
  assert_unlock_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !locked);

  // R8: power-down keeps lock low
  assert_pd_unlock_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> !locked);
endmodule

// File: rtl/cfgLoader.sv
module cfgLoader
  import cfgLoaderPkg::*;
#(
  parameter int CFG_W       = 160,
  parameter int NUM_OUT     = 9,
  parameter int LOCK_CYCLES = 1000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shiftClk,
  input  logic               serData,
  input  logic               strobe,
  input  logic               pwrDownN,
  output logic [CFG_W-1:0]   activeCfg,
  output logic               programmed,
  output logic [NUM_OUT-1:0] outSrcSynth,
  output logic [NUM_OUT-1:0] outEnable,
  output logic               locked
);
  ctrlStrobes_t ctl;

  cfgCtrl #(
    .NUM_OUT     (NUM_OUT),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .shiftClk    (shiftClk),
    .strobe      (strobe),
    .pwrDownN    (pwrDownN),
    .ctl         (ctl),
    .programmed  (programmed),
    .outSrcSynth (outSrcSynth),
    .outEnable   (outEnable),
    .locked      (locked)
  );

  cfgDatapath #(
    .CFG_W (CFG_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .serData (serData),
    .holdReg (activeCfg)
  );

  // R6: power-down switches all drivers off and locked low together
  assert_pd_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |-> (outEnable == '0) && !locked);
endmodule

// File: tb/sim_cfgLoader.sv
module sim_cfgLoader;
  localparam int W    = 160;
  localparam int NO   = 9;
  localparam int LOCK = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClk = 1'b0;
  logic serData = 1'b0;
  logic strobe = 1'b0;
  logic pwrDownN = 1'b1;
  logic [W-1:0]  activeCfg;
  logic          programmed;
  logic [NO-1:0] outSrcSynth;
  logic [NO-1:0] outEnable;
  logic          locked;

  int total = 0;
  int bad = 0;
  logic [W-1:0] model;
  logic [W-1:0] patA;
  logic [W-1:0] patB;
  logic [W-1:0] snap;

  always #5 clk = ~clk;

  cfgLoader #(.CFG_W(W), .NUM_OUT(NO), .LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .serData(serData),
    .strobe(strobe), .pwrDownN(pwrDownN), .activeCfg(activeCfg),
    .programmed(programmed), .outSrcSynth(outSrcSynth),
    .outEnable(outEnable), .locked(locked)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk);
    serData  = b;
    shiftClk = 1'b1;
    waitN(2);
    shiftClk = 1'b0;
    waitN(1);
    model = {model[W-2:0], b};
  endtask

  task automatic pulseStrobe();
    @(negedge clk);
    strobe = 1'b1;
    waitN(2);
    strobe = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < W; i++) begin
      patA[i] = ((i * 5 + 1) % 7) < 3;
      patB[i] = (i % 3) == 0;
    end
    model = '0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R9 reset state
    chk("R9 cfg", activeCfg, '0);
    chk("R9 prog", W'(programmed), W'(0));
    chk("R9 locked", W'(locked), W'(1));
    chk("R5 ref src", W'(outSrcSynth), W'(0));
    chk("R6 enable on", W'(outEnable), W'({NO{1'b1}}));

    // R3: full word with strobe low, latch unchanged
    for (int i = W - 1; i >= 0; i--) shiftBit(patA[i]);
    chk("R3 no leak", activeCfg, '0);
    chk("R5 still ref", W'(outSrcSynth), W'(0));

    // R2: strobe copies word
    pulseStrobe();
    chk("R2 latched", activeCfg, patA);
    chk("R1 msb first", W'(activeCfg[W-1]), W'(patA[W-1]));
    chk("R5 prog set", W'(programmed), W'(1));
    chk("R5 synth src", W'(outSrcSynth), W'({NO{1'b1}}));
    chk("R7 unlocked", W'(locked), W'(0));
    // last strobe-high edge is just before this negedge; lock at +LOCK edges
    waitN(LOCK - 3);
    chk("R7 still unlocked", W'(locked), W'(0));
    waitN(6);
    chk("R7 relocked", W'(locked), W'(1));

    // R3: new word with strobe low, latch keeps A
    for (int i = W - 1; i >= 0; i--) shiftBit(patB[i]);
    chk("R3 hold A", activeCfg, patA);

    // R4: strobe high, each bit visible
    @(negedge clk);
    strobe = 1'b1;
    waitN(2);
    chk("R4 open", activeCfg, model);
    for (int i = W - 1; i >= 0; i--) begin
      shiftBit(patA[i]);
      waitN(1);
      chk("R4 per bit", activeCfg, model);
    end
    strobe = 1'b0;
    waitN(1);
    chk("R1 full word", activeCfg, patA);
    chk("R7 low after transparent", W'(locked), W'(0));
    waitN(LOCK + 4);
    chk("R7 locked", W'(locked), W'(1));

    // R6/R8 power-down
    @(negedge clk);
    pwrDownN = 1'b0;
    waitN(1);
    chk("R6 enables off", W'(outEnable), W'(0));
    chk("R8 pd unlocked", W'(locked), W'(0));
    waitN(LOCK + 5);
    chk("R8 still unlocked", W'(locked), W'(0));
    chk("R6 cfg kept", activeCfg, patA);
    pwrDownN = 1'b1;
    waitN(1);
    chk("R6 enables on", W'(outEnable), W'({NO{1'b1}}));
    chk("R8 wake unlocked", W'(locked), W'(0));
    waitN(LOCK - 4);
    chk("R8 wait", W'(locked), W'(0));
    waitN(6);
    chk("R8 relock", W'(locked), W'(1));

    // R9/R5 second reset clears flag
    @(negedge clk);
    rstN = 1'b0;
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    chk("R9 cfg cleared", activeCfg, '0);
    chk("R5 flag cleared", W'(programmed), W'(0));
    chk("R5 ref again", W'(outSrcSynth), W'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule